// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a logical address, made of a segment register choice and an offset, into a linear address. It holds a cached copy of the descriptor for each of six segment registers. Each copy holds a base, a 20-bit limit, a granularity bit and a present bit, and is loaded through a plain descriptor-load port. A request names a segment, an offset, an access size and whether the core is in 64-bit mode. One cycle later the block returns the linear address, or a fault code when the access is out of bounds, targets an absent segment, or names no segment at all.

In legacy protected mode the low 32 bits of the base and the offset are added modulo 2^32, and the access is checked against the effective limit. In 64-bit mode the four ordinary segments (ES, CS, SS, DS) have no base and no checks, so the linear address is the full 64-bit offset. FS and GS still add their full 64-bit base and still need their present bit. No limit check is made in 64-bit mode.

Requests and results are valid/ready streams. A request is taken on a cycle where `rq_valid` and `rq_ready` are both high. `rq_ready` is high whenever the result register is empty or is being drained in the same cycle. While `rs_valid` is high and `rs_ready` is low, every result field holds its value, and no new request is taken.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rs_valid` is 0 and all six descriptor copies are absent, so a legacy-mode request to any segment returns fault code 2.
- R2: Segment select encoding is ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. In legacy mode (`rq_long`=0) a passing access returns `rs_lin` = {32'b0, (base[31:0] + off[31:0]) mod 2^32}, and offset bits 63:32 are ignored.
- R3: In legacy mode with granularity 0 the effective limit is the 20-bit limit in bytes. The access size is 2^`rq_size` bytes (codes 0..3 give 1, 2, 4 and 8 bytes). The access is in bounds when off[31:0] + size - 1, computed without wraparound, is no greater than the effective limit.
- R4: With granularity 1 the effective limit is (limit << 12) | 0xFFF. An access whose last byte passes 0xFFFFFFFF is out of bounds.
- R5: A limit violation gives `rs_code`=1 and `rs_fault`=1, with `rs_addr_ok`=0 and `rs_lin`=0. Every faulting result has `rs_addr_ok`=0 and `rs_lin`=0, and a passing result has `rs_code`=0, `rs_fault`=0 and `rs_addr_ok`=1.
- R6: The present bit is checked wherever the base is used: all segments in legacy mode, and FS/GS in 64-bit mode. When it is clear the result is `rs_code`=2, and this takes priority over a limit violation.
- R7: In 64-bit mode, ES/CS/SS/DS return `rs_lin` = the full 64-bit offset with code 0, whatever their descriptor holds, present or not.
- R8: In 64-bit mode, FS/GS return base + offset modulo 2^64, with no limit check.
- R9: A select value of 6 or 7 returns `rs_code`=3, taking priority over every other fault.
- R10: A result appears on the cycle after its request is taken. `rq_ready` = !`rs_valid` || `rs_ready`, and a stalled result holds all of its fields stable.
- R11: A descriptor load (`dl_en`, `dl_sel` < 6) affects requests taken from the next cycle on. A request taken in the same cycle as the load sees the old descriptor. Loads with `dl_sel` of 6 or 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_en | input | 1 | Descriptor load strobe |
| dl_sel | input | 3 | Segment register being loaded |
| dl_base | input | 64 | Base to load |
| dl_limit | input | 20 | Limit to load |
| dl_gran | input | 1 | Granularity to load (1 = 4 KiB units) |
| dl_present | input | 1 | Present bit to load |
| rq_valid | input | 1 | Request valid |
| rq_ready | output | 1 | Request accepted when high with rq_valid |
| rq_sel | input | 3 | Segment register select |
| rq_off | input | 64 | Offset |
| rq_long | input | 1 | 1 = 64-bit mode |
| rq_size | input | 2 | Access size code, 2^code bytes |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result consumer ready |
| rs_lin | output | 64 | Linear address (0 on fault) |
| rs_addr_ok | output | 1 | Address usable strobe |
| rs_fault | output | 1 | Any fault |
| rs_code | output | 2 | 0 none, 1 limit, 2 absent, 3 bad select |

## Verification
Two functions can fall in the same cycle: a descriptor load and a request to the same segment register. The bench provokes this directly by asserting both at one edge, for a segment whose old and new descriptors would give different answers (absent versus present with a new base). The result must follow the old copy, and the next request must follow the new one. In the random phase, loads, requests and result stalls overlap freely, and every cycle is compared against a behavioural model that applies the load after computing the request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LIMIT  = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_BADSEL = 2'd3
  } flt_e;

  localparam int SEG_ES = 0;
  localparam int SEG_CS = 1;
  localparam int SEG_SS = 2;
  localparam int SEG_DS = 3;
  localparam int SEG_FS = 4;
  localparam int SEG_GS = 5;

endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache #(
  parameter int NSEG   = 6,
  parameter int BASE_W = 64,
  parameter int LIM_W  = 20,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              wr_gran,
  input  logic              wr_present,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic              rd_hit,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output logic              rd_gran,
  output logic              rd_present
);

  logic [BASE_W-1:0] ent_base    [NSEG];
  logic [LIM_W-1:0]  ent_limit   [NSEG];
  logic              ent_gran    [NSEG];
  logic              ent_present [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_base[i]    <= '0;
        ent_limit[i]   <= '0;
        ent_gran[i]    <= 1'b0;
        ent_present[i] <= 1'b0;
      end else if (wr_en && (wr_sel == SEL_W'(i))) begin
        ent_base[i]    <= wr_base;
        ent_limit[i]   <= wr_limit;
        ent_gran[i]    <= wr_gran;
        ent_present[i] <= wr_present;
      end
    end
  end

  always_comb begin
    rd_hit     = 1'b0;
    rd_base    = '0;
    rd_limit   = '0;
    rd_gran    = 1'b0;
    rd_present = 1'b0;
    for (int k = 0; k < NSEG; k++) begin
      if (rd_sel == SEL_W'(k)) begin
        rd_hit     = 1'b1;
        rd_base    = ent_base[k];
        rd_limit   = ent_limit[k];
        rd_gran    = ent_gran[k];
        rd_present = ent_present[k];
      end
    end
  end

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_sel) < NSEG)) |=>
      (ent_present[$past(wr_sel)] == $past(wr_present)) &&
      (ent_base[$past(wr_sel)] == $past(wr_base))); // R11

endmodule

// File: rtl/seg_bound_chk.sv
module seg_bound_chk #(
  parameter int LEG_W   = 32,
  parameter int LIM_W   = 20,
  parameter int PAGE_SH = 12,
  parameter int SZ_W    = 2
) (
  input  logic [LEG_W-1:0] off,
  input  logic [SZ_W-1:0]  size,
  input  logic [LIM_W-1:0] limit,
  input  logic             gran,
  output logic             viol
);

  localparam int EFF_W = LEG_W + 1;

  logic [EFF_W-1:0] eff_lim;
  logic [EFF_W-1:0] span_m1;
  logic [EFF_W-1:0] last_byte;

  always_comb begin
    if (gran) eff_lim = EFF_W'({limit, {PAGE_SH{1'b1}}});
    else      eff_lim = EFF_W'(limit);
    span_m1   = (EFF_W'(1) << size) - EFF_W'(1);
    last_byte = {1'b0, off} + span_m1;
    viol      = last_byte > eff_lim;
  end

  always_comb begin
    if (gran && (off < LEG_W'(1 << PAGE_SH)) && (size == '0))
      AST_PAGE_COVER: assert (!viol); // R4
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int AW    = 64,
  parameter int LEG_W = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] off,
  input  logic          long_mode,
  input  logic          keep_base,
  output logic [AW-1:0] lin
);

  logic [LEG_W-1:0] leg_sum;

  always_comb begin
    leg_sum = base[LEG_W-1:0] + off[LEG_W-1:0];
    if (!long_mode)     lin = AW'(leg_sum);
    else if (keep_base) lin = base + off;
    else                lin = off;
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int AW      = 64,
  parameter int LEG_W   = 32,
  parameter int LIM_W   = 20,
  parameter int PAGE_SH = 12,
  parameter int NSEG    = 6,
  parameter int SZ_W    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dl_en,
  input  logic [2:0]    dl_sel,
  input  logic [AW-1:0] dl_base,
  input  logic [LIM_W-1:0] dl_limit,
  input  logic          dl_gran,
  input  logic          dl_present,
  input  logic          rq_valid,
  output logic          rq_ready,
  input  logic [2:0]    rq_sel,
  input  logic [AW-1:0] rq_off,
  input  logic          rq_long,
  input  logic [SZ_W-1:0] rq_size,
  output logic          rs_valid,
  input  logic          rs_ready,
  output logic [AW-1:0] rs_lin,
  output logic          rs_addr_ok,
  output logic          rs_fault,
  output logic [1:0]    rs_code
);

  localparam int SEL_W = 3;

  logic          c_hit;
  logic [AW-1:0] c_base;
  logic [LIM_W-1:0] c_limit;
  logic          c_gran;
  logic          c_present;
  logic          lim_viol;
  logic [AW-1:0] lin_raw;
  logic          sel_fsgs;
  logic          need_present;
  flt_e          nxt_code;
  logic          take;
  logic          r_long;

  seg_desc_cache #(
    .NSEG(NSEG), .BASE_W(AW), .LIM_W(LIM_W), .SEL_W(SEL_W)
  ) u_cache (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dl_en), .wr_sel(dl_sel), .wr_base(dl_base),
    .wr_limit(dl_limit), .wr_gran(dl_gran), .wr_present(dl_present),
    .rd_sel(rq_sel), .rd_hit(c_hit), .rd_base(c_base),
    .rd_limit(c_limit), .rd_gran(c_gran), .rd_present(c_present)
  );

  seg_bound_chk #(
    .LEG_W(LEG_W), .LIM_W(LIM_W), .PAGE_SH(PAGE_SH), .SZ_W(SZ_W)
  ) u_bound (
    .off(rq_off[LEG_W-1:0]), .size(rq_size),
    .limit(c_limit), .gran(c_gran), .viol(lim_viol)
  );

  assign sel_fsgs = (rq_sel == SEL_W'(SEG_FS)) || (rq_sel == SEL_W'(SEG_GS));

  seg_addr_gen #(
    .AW(AW), .LEG_W(LEG_W)
  ) u_addr (
    .base(c_base), .off(rq_off), .long_mode(rq_long),
    .keep_base(sel_fsgs), .lin(lin_raw)
  );

  always_comb begin
    need_present = !rq_long || sel_fsgs;
    if (!c_hit)                          nxt_code = FLT_BADSEL;
    else if (need_present && !c_present) nxt_code = FLT_ABSENT;
    else if (!rq_long && lim_viol)       nxt_code = FLT_LIMIT;
    else                                 nxt_code = FLT_NONE;
  end

  assign rq_ready = !rs_valid || rs_ready;
  assign take     = rq_valid && rq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid   <= 1'b0;
      rs_lin     <= '0;
      rs_addr_ok <= 1'b0;
      rs_fault   <= 1'b0;
      rs_code    <= FLT_NONE;
      r_long     <= 1'b0;
    end else if (take) begin
      rs_valid   <= 1'b1;
      rs_lin     <= (nxt_code == FLT_NONE) ? lin_raw : '0;
      rs_addr_ok <= (nxt_code == FLT_NONE);
      rs_fault   <= (nxt_code != FLT_NONE);
      rs_code    <= nxt_code;
      r_long     <= rq_long;
    end else if (rs_ready) begin
      rs_valid   <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=>
      (rs_valid && $stable(rs_lin) && $stable(rs_code) && $stable(rs_addr_ok))); // R10

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready) |=> rs_valid); // R10

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_fault) |-> (!rs_addr_ok && (rs_lin == '0))); // R5

  AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !r_long) |-> (rs_lin[AW-1:LEG_W] == '0)); // R2

  AST_LONG_NO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && r_long) |-> (rs_code != FLT_LIMIT)); // R7

endmodule

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dl_en = 1'b0;
  logic [2:0]  dl_sel = '0;
  logic [63:0] dl_base = '0;
  logic [19:0] dl_limit = '0;
  logic        dl_gran = 1'b0;
  logic        dl_present = 1'b0;
  logic        rq_valid = 1'b0;
  logic        rq_ready;
  logic [2:0]  rq_sel = '0;
  logic [63:0] rq_off = '0;
  logic        rq_long = 1'b0;
  logic [1:0]  rq_size = '0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic [63:0] rs_lin;
  logic        rs_addr_ok;
  logic        rs_fault;
  logic [1:0]  rs_code;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n),
    .dl_en(dl_en), .dl_sel(dl_sel), .dl_base(dl_base), .dl_limit(dl_limit),
    .dl_gran(dl_gran), .dl_present(dl_present),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_sel(rq_sel), .rq_off(rq_off),
    .rq_long(rq_long), .rq_size(rq_size),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_lin(rs_lin),
    .rs_addr_ok(rs_addr_ok), .rs_fault(rs_fault), .rs_code(rs_code)
  );

  // behavioural model state
  logic [63:0] m_base [6];
  logic [19:0] m_lim  [6];
  bit          m_gran [6];
  bit          m_pres [6];
  bit          m_valid = 0;
  logic [63:0] m_lin = '0;
  int          m_code = 0;
  string       m_tag = "R1";
  bit          m_rdy;

  function automatic void ref_xlate(input int sel, input logic [63:0] off,
                                    input bit lng, input int sz,
                                    output logic [63:0] lin, output int code,
                                    output string tag);
    longint unsigned eff, last;
    lin = '0;
    if (sel > 5) begin
      code = 3; tag = "R9";
    end else if (lng) begin
      if (sel >= 4) begin
        if (!m_pres[sel]) begin code = 2; tag = "R6"; end
        else begin code = 0; lin = m_base[sel] + off; tag = "R8"; end
      end else begin
        code = 0; lin = off; tag = "R7";
      end
    end else if (!m_pres[sel]) begin
      code = 2; tag = "R6";
    end else begin
      if (m_gran[sel]) eff = longint'(m_lim[sel]) * 4096 + 4095;
      else             eff = longint'(m_lim[sel]);
      last = longint'(off[31:0]) + (64'd1 << sz) - 1;
      if (last > eff) begin code = 1; tag = "R5"; end
      else begin
        code = 0;
        lin = {32'b0, m_base[sel][31:0] + off[31:0]};
        tag = "R2";
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0;
      for (int i = 0; i < 6; i++) begin
        m_pres[i] = 0; m_gran[i] = 0; m_lim[i] = '0; m_base[i] = '0;
      end
    end else begin
      m_rdy = !m_valid || rs_ready;
      if (m_valid && rs_ready) m_valid = 0;
      if (rq_valid && m_rdy) begin
        ref_xlate(int'(rq_sel), rq_off, rq_long, int'(rq_size), m_lin, m_code, m_tag);
        m_valid = 1;
      end
      if (dl_en && dl_sel < 3'd6) begin
        m_base[dl_sel] = dl_base; m_lim[dl_sel] = dl_limit;
        m_gran[dl_sel] = dl_gran; m_pres[dl_sel] = dl_present;
      end
    end
    #2;
    vectors++;
    if (rs_valid !== m_valid || rq_ready !== (!m_valid || rs_ready)) begin
      miscompares++;
      $display("FAIL R10 (phase %s) valid/ready got %0b/%0b exp %0b/%0b",
               phase, rs_valid, rq_ready, m_valid, (!m_valid || rs_ready));
    end else if (m_valid && (rs_lin !== m_lin || int'(rs_code) != m_code ||
                 rs_fault !== (m_code != 0) || rs_addr_ok !== (m_code == 0))) begin
      miscompares++;
      $display("FAIL %s (phase %s) lin/code/fault/ok got %h/%0d/%0b/%0b exp %h/%0d/%0b/%0b",
               m_tag, phase, rs_lin, rs_code, rs_fault, rs_addr_ok,
               m_lin, m_code, (m_code != 0), (m_code == 0));
    end
  end

  // tasks: entered and left at a negative edge
  task automatic load(input int sel, input logic [63:0] base, input logic [19:0] lim,
                      input bit gran, input bit pres);
    dl_en = 1; dl_sel = 3'(sel); dl_base = base; dl_limit = lim;
    dl_gran = gran; dl_present = pres;
    @(negedge clk);
    dl_en = 0;
  endtask

  task automatic req(input int sel, input logic [63:0] off, input bit lng, input int sz);
    bit acc;
    rq_valid = 1; rq_sel = 3'(sel); rq_off = off; rq_long = lng; rq_size = 2'(sz);
    do begin
      acc = rq_ready;
      @(negedge clk);
    end while (!acc);
    rq_valid = 0;
  endtask

  task automatic load_and_req(input int sel, input logic [63:0] base, input logic [19:0] lim,
                              input bit pres, input logic [63:0] off);
    dl_en = 1; dl_sel = 3'(sel); dl_base = base; dl_limit = lim;
    dl_gran = 0; dl_present = pres;
    rq_valid = 1; rq_sel = 3'(sel); rq_off = off; rq_long = 0; rq_size = 0;
    @(negedge clk);
    dl_en = 0; rq_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state, then absent descriptors
    phase = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    req(3, 64'h10, 0, 0);
    req(1, 64'h0, 0, 0);
    idle(1);

    // R2: legacy sum, wrap and ignored upper offset bits
    phase = "R2";
    load(3, 64'h0000_0000_1000_0000, 20'hFFFFF, 1, 1);
    req(3, 64'h1234, 0, 0);
    load(3, 64'hFFFF_FFFF_FFFF_F000, 20'hFFFFF, 1, 1);
    req(3, 64'h2000, 0, 2);
    req(3, 64'hABCD_0000_0000_0010, 0, 0);

    // R3: byte granularity edges for every size
    phase = "R3";
    load(0, 64'h0, 20'h000FF, 0, 1);
    req(0, 64'hFF, 0, 0);
    req(0, 64'hFF, 0, 1);
    req(0, 64'hFC, 0, 2);
    req(0, 64'hFD, 0, 2);
    req(0, 64'hF8, 0, 3);
    req(0, 64'hF9, 0, 3);

    // R4: page granularity edges and top-of-space wrap
    phase = "R4";
    load(2, 64'h500, 20'h00002, 1, 1);
    req(2, 64'h2FFF, 0, 0);
    req(2, 64'h3000, 0, 0);
    load(2, 64'h0, 20'hFFFFF, 1, 1);
    req(2, 64'hFFFF_FFFF, 0, 0);
    req(2, 64'hFFFF_FFFF, 0, 1);

    // R5/R6: absent beats limit
    phase = "R6";
    req(4, 64'h0, 0, 0);
    load(5, 64'h0, 20'h0, 0, 0);
    req(5, 64'h100, 0, 0);
    phase = "R5";
    load(5, 64'h0, 20'h0, 0, 1);
    req(5, 64'h100, 0, 0);

    // R7: long mode ordinary segments pass the offset through
    phase = "R7";
    req(1, 64'hFEDC_BA98_7654_3210, 1, 3);
    req(0, 64'h0000_0001_0000_0000, 1, 0);
    load(3, 64'h0, 20'h0, 0, 0);
    req(3, 64'h1234_5678_9ABC_DEF0, 1, 0);

    // R8: long mode FS/GS keep their base
    phase = "R8";
    load(4, 64'h0000_7F00_0000_0000, 20'h0, 0, 1);
    req(4, 64'h10, 1, 0);
    req(4, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
    req(4, 64'h0, 0, 0);
    req(5, 64'h8000_0000, 1, 2);
    load(5, 64'h0, 20'h0, 0, 0);
    req(5, 64'h8, 1, 0);

    // R9: bad selects
    phase = "R9";
    req(6, 64'h0, 0, 0);
    req(7, 64'h0, 1, 0);

    // R10: back-pressure
    phase = "R10";
    rs_ready = 0;
    fork
      begin
        req(0, 64'h10, 0, 0);
        req(0, 64'h20, 0, 0);
      end
      begin
        idle(4); #1 rs_ready = 1;
      end
    join
    idle(2);

    // R11: load and request in the same cycle
    phase = "R11";
    load(1, 64'h0, 20'h0, 0, 0);
    load_and_req(1, 64'h4000, 20'hFFFF, 1, 64'h10);
    req(1, 64'h10, 0, 0);
    load(7, 64'h9999, 20'hFFFFF, 0, 1);
    req(7, 64'h0, 0, 0);
    idle(1);

    // mixed random traffic with stalls
    phase = "mix";
    fork
      begin
        for (int n = 0; n < 400; n++) begin
          if ($urandom_range(0, 3) == 0)
            load($urandom_range(0, 7), {$urandom, $urandom},
                 20'($urandom_range(0, 3) == 0 ? $urandom_range(0, 3) : $urandom_range(0, 16'h3FFF)),
                 $urandom_range(0, 1), $urandom_range(0, 4) != 0);
          if ($urandom_range(0, 1) == 0)
            load_and_req($urandom_range(0, 5), {$urandom, $urandom},
                         20'($urandom_range(0, 16'h3FFF)), $urandom_range(0, 1),
                         64'($urandom_range(0, 16'h3FFF)));
          else
            req($urandom_range(0, 7),
                ($urandom_range(0, 3) == 0) ? {$urandom, $urandom}
                                            : 64'($urandom_range(0, 16'h4FFF)),
                $urandom_range(0, 2) == 0, $urandom_range(0, 3));
        end
      end
      begin
        for (int n = 0; n < 900; n++) begin
          @(negedge clk);
          #1 rs_ready = ($urandom_range(0, 3) != 0);
        end
        rs_ready = 1;
      end
    join
    rs_ready = 1;
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule